// File: doc/BRIEF.md
# Two-Pin GPIO Register Controller

This block holds the software-visible state of two general-purpose pins inside an audio codec's control space. Two 16-bit registers are reached through a word-wide read/write port: an interrupt enable register (one bit per pin) and a pin state register (one bit per pin). Bit 0 of each register belongs to pin 0 and bit 1 to pin 1. All other bits read back as zero.

A pin set as an output drives either its state-register bit or a value delivered in serial frame slot 12. One static select input makes that choice. A pin set as an input is resynchronised with two flops and optionally inverted. Its state bit then either follows the pad level or, in sticky mode, latches the active level until software clears it by writing zero. The state bits of input pins, gated by the enable register, are ORed into one registered interrupt bit for slot 12. Pin direction, polarity, sticky mode and the slot select are static inputs driven by configuration logic outside this block.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset the enable register, the state register, `reg_rdata`, `slot_irq` and the output-mode pad values are all 0.
- R2: The enable register is at address 0x52 and the state register at 0x54. Bit 0 is pin 0 and bit 1 is pin 1. Bits 15:2 always read 0. An address presented in one cycle returns its data on `reg_rdata` after the next clock edge. Any other address reads 0.
- R3: For an output pin (`pin_is_input` bit = 0) with `slot_select` = 0, `pad_out` shows the state bit last written. The state bit holds when no write occurs.
- R4: For an output pin with `slot_select` = 1, `pad_out` equals that pin's bit of `slot_pin_val`. The state bit stays readable and unchanged.
- R5: For a non-sticky input pin, the state bit equals pad level XOR `pin_invert` bit. It reflects a pad change three clock edges after the change. Writes to it have no lasting effect.
- R6: For a sticky input pin, the state bit sets when the inverted level is 1 and stays set after the level drops. Writing 1 to it has no effect.
- R7: Writing 0 to a sticky input's state bit clears it. If the active level is present in the same cycle as that clearing write, the bit stays set.
- R8: `slot_irq` is a register updated every cycle. It is the OR over pins of state bit AND enable bit AND input mode. It is 0 whenever the enable register is 0. Output pins never raise it.
- R9: An input pin drives 0 on its `pad_out` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after address |
| pin_is_input | input | 2 | Per-pin direction, 1 = input |
| pin_invert | input | 2 | Per-pin input polarity inversion |
| pin_sticky | input | 2 | Per-pin sticky capture mode |
| slot_select | input | 1 | 1 = output pins take slot-12 data |
| slot_pin_val | input | 2 | Pin values received in slot 12 |
| pad_in | input | 2 | Asynchronous pad levels |
| pad_out | output | 2 | Values driven to the pads |
| slot_irq | output | 1 | Combined interrupt bit for slot 12 |

## Verification
The case that matters most is a sticky input whose active level arrives in the same cycle as a software write of zero to its state bit. The bench holds the pad active for several cycles, so the synchronised level is certainly present on the write edge, and then issues the clearing write. The state bit must read back as 1; set beats clear. The bench then drops the pad, waits out the synchronizer delay and repeats the write. This time the bit must read 0, which shows that the earlier survival was due to priority and not to a broken clear path.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
    localparam int NPIN    = 2;
    localparam int DW      = 16;
    localparam int AW      = 7;
    localparam logic [AW-1:0] ADDR_EN    = 7'h52;
    localparam logic [AW-1:0] ADDR_STATE = 7'h54;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [NPIN-1:0] en;
        logic [DW-1:0]   rdata;
        logic            irq;
    } ctrl_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bit_cell.sv
module gpio_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,      // synchronised, polarity-corrected pad level
    input  logic is_in,
    input  logic sticky,
    input  logic wr_hit,   // write to the state register this cycle
    input  logic wbit,
    output logic stat
);
    logic stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (is_in) begin
            if (sticky) begin
                if (wr_hit && !wbit) stat_d = 1'b0;
                if (lvl)             stat_d = 1'b1;   // set wins over clear
            end else begin
                stat_d = lvl;
            end
        end else if (wr_hit) begin
            stat_d = wbit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_in && sticky && stat_q && !(wr_hit && !wbit)) |=> stat_q);

    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_in && sticky && lvl) |=> stat_q);

    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_in && !wr_hit) |=> $stable(stat_q));

    p_follow_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_in && !sticky) |=> (stat_q == $past(lvl)));
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
    import gpio_pair_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NPIN-1:0] pin_is_input,
    input  logic [NPIN-1:0] pin_invert,
    input  logic [NPIN-1:0] pin_sticky,
    input  logic            slot_select,
    input  logic [NPIN-1:0] slot_pin_val,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic            slot_irq
);
    ctrl_state_t st_d, st_q;
    logic [NPIN-1:0] pad_sync, lvl, state_bits;
    logic            wr_state, wr_en;

    assign wr_state = reg_wr && (reg_addr == ADDR_STATE);
    assign wr_en    = reg_wr && (reg_addr == ADDR_EN);

    gpio_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_sync)
    );

    assign lvl = pad_sync ^ pin_invert;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_bit_cell u_cell (
            .clk(clk), .rst_n(rst_n), .lvl(lvl[i]),
            .is_in(pin_is_input[i]), .sticky(pin_sticky[i]),
            .wr_hit(wr_state), .wbit(reg_wdata[i]), .stat(state_bits[i])
        );
        assign pad_out[i] = pin_is_input[i] ? 1'b0
                          : (slot_select ? slot_pin_val[i] : state_bits[i]);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.en = reg_wdata[NPIN-1:0];
        unique case (reg_addr)
            ADDR_EN:    st_d.rdata = {{(DW-NPIN){1'b0}}, st_q.en};
            ADDR_STATE: st_d.rdata = {{(DW-NPIN){1'b0}}, state_bits};
            default:    st_d.rdata = '0;
        endcase
        st_d.irq = |(state_bits & st_q.en & pin_is_input);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign slot_irq  = st_q.irq;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:NPIN] == '0);

    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != ADDR_EN && reg_addr != ADDR_STATE) |=> (reg_rdata == '0));

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |=> !slot_irq);

    p_out_only_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_is_input == '0) |=> !slot_irq);
endmodule

// File: tb/sim_gpio_pair_ctrl.sv
module sim_gpio_pair_ctrl;
    logic        clk = 0;
    logic        rst_n;
    logic [6:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [1:0]  pin_is_input, pin_invert, pin_sticky, slot_pin_val, pad_in, pad_out;
    logic        slot_select, slot_irq;
    int tests = 0, fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_pair_ctrl u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] dir, input logic [1:0] inv,
                            input logic [1:0] stk, input logic sel);
        @(negedge clk);
        rst_n = 0; reg_wr = 0; reg_addr = 7'h00; reg_wdata = 0;
        pin_is_input = dir; pin_invert = inv; pin_sticky = stk;
        slot_select = sel; slot_pin_val = 0; pad_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_read(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic t_reset_state;
        logic [15:0] v;
        do_reset(2'b00, 2'b00, 2'b00, 1'b0);
        chk("R1 rdata", reg_rdata, 16'h0);
        chk("R1 irq", {15'b0, slot_irq}, 16'h0);
        chk("R1 pad_out", {14'b0, pad_out}, 16'h0);
        do_read(7'h52, v); chk("R1 enable reg", v, 16'h0);
        do_read(7'h54, v); chk("R1 state reg", v, 16'h0);
    endtask

    task automatic t_map;
        logic [15:0] v;
        do_reset(2'b00, 2'b00, 2'b00, 1'b0);
        do_write(7'h52, 16'hFFFF);
        do_read(7'h52, v); chk("R2 enable reserved zero", v, 16'h0003);
        do_write(7'h54, 16'hFFFE);
        do_read(7'h54, v); chk("R2 state reserved zero", v, 16'h0002);
        do_read(7'h53, v); chk("R2 unmapped 0x53", v, 16'h0);
        do_read(7'h74, v); chk("R2 unmapped 0x74", v, 16'h0);
    endtask

    task automatic t_output_reg;
        logic [15:0] v;
        do_reset(2'b00, 2'b00, 2'b00, 1'b0);
        do_write(7'h54, 16'h0001);
        chk("R3 pad from reg 01", {14'b0, pad_out}, 16'h0001);
        do_write(7'h54, 16'h0002);
        chk("R3 pad from reg 10", {14'b0, pad_out}, 16'h0002);
        repeat (3) @(negedge clk);
        chk("R3 hold", {14'b0, pad_out}, 16'h0002);
    endtask

    task automatic t_output_slot;
        logic [15:0] v;
        do_reset(2'b00, 2'b00, 2'b00, 1'b1);
        do_write(7'h54, 16'h0001);
        @(negedge clk); slot_pin_val = 2'b10; #1;
        chk("R4 pad from slot", {14'b0, pad_out}, 16'h0002);
        do_read(7'h54, v); chk("R4 state unchanged", v, 16'h0001);
    endtask

    task automatic t_input_plain;
        logic [15:0] v;
        do_reset(2'b11, 2'b10, 2'b00, 1'b0);
        // pad 00, invert pin1 -> state 10
        repeat (4) @(negedge clk);
        do_read(7'h54, v); chk("R5 inverted idle", v, 16'h0002);
        chk("R9 input pads quiet", {14'b0, pad_out}, 16'h0);
        do_write(7'h54, 16'h0001);
        do_read(7'h54, v); chk("R5 write ignored", v, 16'h0002);
        @(negedge clk); pad_in = 2'b01;
        @(negedge clk); @(negedge clk);
        reg_addr = 7'h54;
        @(negedge clk);   // third edge updates state
        @(negedge clk);   // rdata shows it
        chk("R5 follows pad after 3 edges", reg_rdata, 16'h0003);
    endtask

    task automatic t_sticky;
        logic [15:0] v;
        do_reset(2'b11, 2'b00, 2'b11, 1'b0);
        @(negedge clk); pad_in = 2'b01;
        repeat (4) @(negedge clk);
        pad_in = 2'b00;
        repeat (4) @(negedge clk);
        do_read(7'h54, v); chk("R6 latched after drop", v, 16'h0001);
        do_write(7'h54, 16'h0003);
        do_read(7'h54, v); chk("R6 write 1 no effect", v, 16'h0001);
        do_write(7'h54, 16'h0000);
        do_read(7'h54, v); chk("R7 write 0 clears", v, 16'h0000);
        // concurrent set and clear
        @(negedge clk); pad_in = 2'b10;
        repeat (4) @(negedge clk);
        do_write(7'h54, 16'h0000);
        do_read(7'h54, v); chk("R7 set beats clear", v, 16'h0002);
        pad_in = 2'b00;
        repeat (4) @(negedge clk);
        do_write(7'h54, 16'h0000);
        do_read(7'h54, v); chk("R7 clear after drop", v, 16'h0000);
    endtask

    task automatic t_irq;
        do_reset(2'b01, 2'b00, 2'b00, 1'b0);
        @(negedge clk); pad_in = 2'b01;
        repeat (5) @(negedge clk);
        chk("R8 masked irq", {15'b0, slot_irq}, 16'h0);
        do_write(7'h52, 16'h0001);
        @(negedge clk);
        chk("R8 enabled irq", {15'b0, slot_irq}, 16'h1);
        do_write(7'h52, 16'h0002);
        do_write(7'h54, 16'h0002);   // pin1 output with state 1
        @(negedge clk);
        chk("R8 output pin no irq", {15'b0, slot_irq}, 16'h0);
        chk("R3 pin1 drives state", {15'b0, pad_out[1]}, 16'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_map();
        t_output_reg();
        t_output_slot();
        t_input_plain();
        t_sticky();
        t_irq();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule